// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Line Errors

This block turns an asynchronous serial line into parallel characters. It samples the incoming line on every system clock, finds a start bit and times each later bit from the selected oversampling factor. It builds a character of 5 to 8 bits, least significant bit first, and can check an optional even or odd parity bit. It then checks the first stop bit. Each finished character goes into a one-entry receive buffer and is offered on a valid/ready output.

The receive path gives no back-pressure to the line. `rx_ready` is the consumer's take strobe. A transfer happens on any clock edge where `rx_valid` and `rx_ready` are both 1, and that transfer empties the buffer. While `rx_valid` is 1, the data does not change unless a new character arrives. A new character always overwrites the buffer; if the old one had not been taken, this is recorded as an overrun. `rx_ready` has no effect while `rx_valid` is 0.

Parity, framing and overrun errors are kept in three sticky flags. Only a pulse on `err_clr` clears them. Taking a character from the buffer leaves them as they are.

The configuration inputs must be held stable while a frame is in flight.

Top module: `async_rx_core`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `pe_flag`, `oe_flag` and `fe_flag` are all 0.
- R2: A start bit is recognised only while `rx_en` is 1. A whole frame sent while `rx_en` is 0 leaves `rx_valid` at 0. Dropping `rx_en` abandons a frame in progress.
- R3: With a clock factor of 16 or 64, a low pulse on `rxd` that has returned high by the half-bit point is rejected and yields no character.
- R4: `char_len` selects the character size: 00 = 5 bits, 01 = 6, 10 = 7, 11 = 8. Bits are assembled least significant first, and `rx_data` bits at and above the character size are 0.
- R5: `clk_fac` selects the bit period: 01 = 1 clock, 10 = 16 clocks, 11 = 64 clocks (00 behaves as 1). Every bit after the start bit is sampled at its midpoint.
- R6: When `par_en` is 1, the bit after the data is a parity bit. With `par_even` = 1, `pe_flag` is set if data plus parity holds an odd number of ones; with `par_even` = 0, it is set if that count is even. When `par_en` is 0, no parity bit is expected and `pe_flag` is never set.
- R7: `fe_flag` is set when `rxd` is low at the first stop-bit sample.
- R8: `oe_flag` is set when a character completes while `rx_valid` is still 1. `rx_data` then holds the new character.
- R9: A take (`rx_valid` and `rx_ready` both 1) clears `rx_valid` and leaves all three error flags unchanged.
- R10: A one-cycle pulse on `err_clr` clears all three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one oversample tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| char_len | input | 2 | Character size code |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| clk_fac | input | 2 | Oversampling factor code |
| rx_en | input | 1 | Receive enable |
| err_clr | input | 1 | Clear the three error flags |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Character waiting in the buffer |
| rx_ready | input | 1 | Consumer takes the character |
| pe_flag | output | 1 | Sticky parity error |
| oe_flag | output | 1 | Sticky overrun error |
| fe_flag | output | 1 | Sticky framing error |

## Verification
A bit counter or phase counter that slips by a single step shows up at `rx_data` as a character shifted by one position, and usually also as a false `fe_flag`. This appears on the first frame after the fault, about half a bit period after the stop bit. A parity accumulator that carries state across frames shows up as a wrong `pe_flag` on the very next frame that has parity. A buffer-valid bit that fails to clear, or a sticky flag that leaks, shows up as a spurious `oe_flag`, or as a flag that drops without `err_clr`. That is visible one frame after the take, or at the cycle after the error event.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;

  // Clocks per bit for a factor code; code 00 is treated as x1.
  function automatic logic [6:0] bit_period(input logic [1:0] fac);
    case (fac)
      2'b10:   bit_period = 7'd16;
      2'b11:   bit_period = 7'd64;
      default: bit_period = 7'd1;
    endcase
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic line_fall
);
  logic [STAGES-1:0] pipe;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= '1;
      last_q <= 1'b1;
    end else begin
      pipe   <= {pipe[STAGES-2:0], line_in};
      last_q <= pipe[STAGES-1];
    end
  end

  assign line_s    = pipe[STAGES-1];
  assign line_fall = last_q & ~pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              line_fall,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic [1:0]        clk_fac,
  input  logic              rx_en,
  output logic              done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_pe,
  output logic              frame_fe
);
  localparam int IDX_W = $clog2(DATA_W);

  rx_state_e        state;
  logic [6:0]       cnt;
  logic [IDX_W-1:0] bidx;
  logic             pbit;
  logic [6:0]       period;
  logic [6:0]       half;
  logic [IDX_W-1:0] last_idx;

  assign period   = bit_period(clk_fac);
  assign half     = period >> 1;
  assign last_idx = IDX_W'(char_len) + IDX_W'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bidx       <= '0;
      pbit       <= 1'b0;
      done       <= 1'b0;
      frame_data <= '0;
      frame_pe   <= 1'b0;
      frame_fe   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!rx_en) begin
        state <= RX_IDLE;
      end else begin
        case (state)
          RX_IDLE: if (line_fall) begin
            frame_data <= '0;
            bidx       <= '0;
            if (period == 7'd1) begin
              state <= RX_DATA;
              cnt   <= '0;
            end else begin
              state <= RX_START;
              cnt   <= half - 7'd1;
            end
          end
          RX_START: begin
            if (cnt == '0) begin
              if (!line_s) begin
                state <= RX_DATA;
                cnt   <= period - 7'd1;
              end else begin
                state <= RX_IDLE;
              end
            end else cnt <= cnt - 7'd1;
          end
          RX_DATA: begin
            if (cnt == '0) begin
              frame_data[bidx] <= line_s;
              cnt              <= period - 7'd1;
              if (bidx == last_idx) state <= par_en ? RX_PAR : RX_STOP;
              else bidx <= bidx + 1'b1;
            end else cnt <= cnt - 7'd1;
          end
          RX_PAR: begin
            if (cnt == '0) begin
              pbit  <= line_s;
              state <= RX_STOP;
              cnt   <= period - 7'd1;
            end else cnt <= cnt - 7'd1;
          end
          RX_STOP: begin
            if (cnt == '0) begin
              done     <= 1'b1;
              frame_fe <= ~line_s;
              frame_pe <= par_en & (^frame_data ^ pbit ^ ~par_even);
              state    <= RX_IDLE;
            end else cnt <= cnt - 7'd1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R3
  start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA && $past(state) == RX_START) |-> !$past(line_s));

  // R2
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rx_en)) |-> (state == RX_IDLE && !done));
endmodule

// File: rtl/rx_buffer_status.sv
module rx_buffer_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_pe,
  input  logic              frame_fe,
  input  logic              rx_ready,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              pe_flag,
  output logic              oe_flag,
  output logic              fe_flag
);
  logic take;
  assign take = rx_valid & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      pe_flag  <= 1'b0;
      oe_flag  <= 1'b0;
      fe_flag  <= 1'b0;
    end else begin
      if (done) begin
        rx_data  <= frame_data;
        rx_valid <= 1'b1;
      end else if (take) begin
        rx_valid <= 1'b0;
      end
      pe_flag <= (pe_flag & ~err_clr) | (done & frame_pe);
      fe_flag <= (fe_flag & ~err_clr) | (done & frame_fe);
      oe_flag <= (oe_flag & ~err_clr) | (done & rx_valid & ~rx_ready);
    end
  end

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_flag) |-> $past(rx_valid));

  // R10
  pe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pe_flag) |-> $past(err_clr));

  // R10
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fe_flag) |-> $past(err_clr));

  // R9
  valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(done));
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic [1:0]        clk_fac,
  input  logic              rx_en,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              pe_flag,
  output logic              oe_flag,
  output logic              fe_flag
);
  logic              line_s, line_fall;
  logic              done, f_pe, f_fe;
  logic [DATA_W-1:0] f_data;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rxd),
    .line_s(line_s), .line_fall(line_fall)
  );

  rx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_s(line_s), .line_fall(line_fall),
    .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .clk_fac(clk_fac), .rx_en(rx_en), .done(done),
    .frame_data(f_data), .frame_pe(f_pe), .frame_fe(f_fe)
  );

  rx_buffer_status #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .done(done), .frame_data(f_data),
    .frame_pe(f_pe), .frame_fe(f_fe), .rx_ready(rx_ready),
    .err_clr(err_clr), .rx_data(rx_data), .rx_valid(rx_valid),
    .pe_flag(pe_flag), .oe_flag(oe_flag), .fe_flag(fe_flag)
  );
endmodule

// File: tb/async_rx_core_tb.sv
module async_rx_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 1'b0, par_even = 1'b0;
  logic [1:0] clk_fac = 2'b10;
  logic       rx_en = 1'b1, err_clr = 1'b0, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, pe_flag, oe_flag, fe_flag;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  async_rx_core u_dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .char_len(char_len),
    .par_en(par_en), .par_even(par_even), .clk_fac(clk_fac),
    .rx_en(rx_en), .err_clr(err_clr), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .pe_flag(pe_flag),
    .oe_flag(oe_flag), .fe_flag(fe_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int per(input logic [1:0] f);
    return (f == 2'b10) ? 16 : (f == 2'b11) ? 64 : 1;
  endfunction

  task automatic drive_bit(input logic b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flip, input logic stop_b);
    int n = per(clk_fac);
    int len = int'(char_len) + 5;
    logic p = 1'b0;
    drive_bit(1'b0, n);
    for (int i = 0; i < len; i++) begin
      drive_bit(d[i], n);
      p = p ^ d[i];
    end
    if (par_en) drive_bit(p ^ ~par_even ^ flip, n);
    drive_bit(stop_b, n);
    drive_bit(1'b1, n + 6);
  endtask

  task automatic take_char();
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; @(negedge clk);
  endtask

  task automatic clear_err();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid", rx_valid, 0); chk("R1 data", rx_data, 0);
    chk("R1 pe", pe_flag, 0); chk("R1 oe", oe_flag, 0); chk("R1 fe", fe_flag, 0);
  endtask

  task automatic t_x16_byte();
    clk_fac = 2'b10; char_len = 2'b11; par_en = 0;
    send_frame(8'hA5, 0, 1);
    chk("R5 x16 valid", rx_valid, 1); chk("R4 x16 data", rx_data, 8'hA5);
    chk("R7 no fe", fe_flag, 0);
    take_char();
    chk("R9 take clears valid", rx_valid, 0);
  endtask

  task automatic t_x1_short();
    clk_fac = 2'b01; char_len = 2'b00;
    send_frame(8'hF3, 0, 1);
    chk("R4 5-bit upper zero", rx_data, 8'h13); chk("R5 x1 valid", rx_valid, 1);
    take_char();
    char_len = 2'b01;
    send_frame(8'hEA, 0, 1);
    chk("R4 6-bit data", rx_data, 8'h2A);
    take_char();
  endtask

  task automatic t_parity();
    clk_fac = 2'b11; char_len = 2'b10; par_en = 1; par_even = 1;
    send_frame(8'h5A, 0, 1);
    chk("R6 even good", pe_flag, 0); chk("R4 7-bit x64", rx_data, 8'h5A);
    take_char();
    par_even = 0;
    send_frame(8'h5A, 0, 1);
    chk("R6 odd good", pe_flag, 0);
    take_char();
    send_frame(8'h33, 1, 1);
    chk("R6 odd bad", pe_flag, 1);
    take_char();
    chk("R9 take keeps pe", pe_flag, 1);
    clear_err();
    chk("R10 pe cleared", pe_flag, 0);
    clk_fac = 2'b10; par_en = 0; char_len = 2'b01;
    send_frame(8'h07, 0, 1);
    chk("R6 disabled", pe_flag, 0); chk("R6 disabled data", rx_data, 8'h07);
    take_char();
  endtask

  task automatic t_framing();
    char_len = 2'b11;
    send_frame(8'h3C, 0, 0);
    chk("R7 fe set", fe_flag, 1);
    take_char();
    chk("R9 take keeps fe", fe_flag, 1);
    clear_err();
    chk("R10 fe cleared", fe_flag, 0);
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 0, 1);
    chk("R8 no oe yet", oe_flag, 0);
    send_frame(8'h22, 0, 1);
    chk("R8 oe set", oe_flag, 1); chk("R8 new data", rx_data, 8'h22);
    take_char();
    clear_err();
    chk("R10 oe cleared", oe_flag, 0);
  endtask

  task automatic t_disabled();
    rx_en = 0;
    send_frame(8'h55, 0, 1);
    chk("R2 ignored", rx_valid, 0);
    rx_en = 1;
  endtask

  task automatic t_glitch();
    clk_fac = 2'b10;
    drive_bit(1'b0, 4); drive_bit(1'b1, 200);
    chk("R3 glitch rejected", rx_valid, 0);
    chk("R3 no fe", fe_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset(); t_x16_byte(); t_x1_short(); t_parity();
    t_framing(); t_overrun(); t_disabled(); t_glitch();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule